// File: doc/BRIEF.md
# CPU Activity Monitor Counter Bank

A per-core bank of 64-bit counters for system management. Four counters have a fixed event assignment: core clock cycles, ticks of a constant-rate reference, retired instructions, and dispatch stall cycles caused by last-level cache misses. A parameter sets how many auxiliary counters exist, from none up to sixteen. Each auxiliary counter counts pulses on its own platform event input. All counting stops while the core reports that it is in a low-power wait state.

Software uses one register port. Each request takes one cycle, and the response comes back on the next cycle. Through this port software can read and write any counter, set or clear bits in the enable mask of each group, and read those masks back. A counter whose enable bit is clear does not count and reads as zero. A single trap flag makes requests from a lower privilege level fail with a fault instead of completing.

Top module: `actmon_bank`

## Requirements
- R1: After reset every counter holds zero, both enable masks are zero and `rsp_valid` is low.
- R2: The fixed counters sit at addresses 0x00 to 0x03. Index 0 counts every clock cycle, index 1 counts `ref_tick` pulses, index 2 counts `inst_retired` pulses and index 3 counts `llc_stall` pulses.
- R3: Auxiliary counter i sits at address 0x10+i and counts `aux_evt[i]`. Only indices below NUM_AUX exist. An index at or above NUM_AUX reads as zero, and a write to it has no effect.
- R4: While `core_wait` is high, no counter advances.
- R5: Address 0x20 sets bits in the fixed-group enable mask and 0x21 clears them. Address 0x22 sets bits in the auxiliary-group mask and 0x23 clears them. A one in the write data sets or clears the matching bit, and a zero leaves that bit unchanged. Reading either address of a group returns that group's mask in the low bits.
- R6: An auxiliary-mask bit at or above NUM_AUX always reads as zero.
- R7: A counter with its enable bit clear keeps its value and does not count. A read of it returns zero. Setting the bit again exposes the held value.
- R8: A counter wraps from all ones to zero and does not saturate.
- R9: A software write to a counter overrides an increment in the same cycle.
- R10: While `trap_lowpriv` is high, a request with `req_lowpriv` high returns `rsp_fault`=1 and `rsp_rdata`=0, and it changes no state.
- R11: `rsp_valid` follows `req_valid` by one cycle. Read data shows the value held before the clock edge that accepts the request. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| core_wait | input | 1 | Core is in a low-power wait state |
| ref_tick | input | 1 | Constant-rate tick, one cycle wide, already synchronized to `clk` |
| inst_retired | input | 1 | An instruction retired this cycle |
| llc_stall | input | 1 | Dispatch stalled this cycle on a last-level cache miss |
| aux_evt | input | 16 | Auxiliary event pulses, one per index |
| trap_lowpriv | input | 1 | Fault lower-privilege requests |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lowpriv | input | 1 | Request comes from a lower privilege level |
| req_addr | input | 8 | Register address |
| req_wdata | input | CNT_W | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_fault | output | 1 | Request was refused by the trap |
| rsp_rdata | output | CNT_W | Read data |

## Verification
The bench builds the bank with NUM_AUX=4, so it exercises both present and absent auxiliary indices, and mask bits above the implemented range, in a single build. Counter width stays at 64. Counting is made exact by holding `core_wait` high while the bench sets up, then lowering it for a known number of cycles. With this, the bench sweeps all sixteen fixed-group enable patterns and checks every counter against arithmetic expectations.

// File: rtl/actmon_pkg.sv
package actmon_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned G0_NUM  = 4;
  localparam int unsigned AUX_MAX = 16;

  typedef enum logic [1:0] {
    EV_CYCLES   = 2'd0,
    EV_REFTICK  = 2'd1,
    EV_RETIRED  = 2'd2,
    EV_LLCSTALL = 2'd3
  } g0_sel_e;

  localparam logic [ADDR_W-1:0] A_G0_SET = 8'h20;
  localparam logic [ADDR_W-1:0] A_G0_CLR = 8'h21;
  localparam logic [ADDR_W-1:0] A_G1_SET = 8'h22;
  localparam logic [ADDR_W-1:0] A_G1_CLR = 8'h23;

  typedef struct packed {
    logic       g0_cnt;
    logic       g1_cnt;
    logic       g0_set;
    logic       g0_clr;
    logic       g1_set;
    logic       g1_clr;
    logic [3:0] idx;
  } decode_t;
endpackage

// File: rtl/actmon_decode.sv
module actmon_decode
  import actmon_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output decode_t           dec
);
  always_comb begin
    dec        = '0;
    dec.g0_cnt = (addr[ADDR_W-1:2] == '0);
    dec.g1_cnt = (addr[ADDR_W-1:4] == 4'h1);
    dec.g0_set = (addr == A_G0_SET);
    dec.g0_clr = (addr == A_G0_CLR);
    dec.g1_set = (addr == A_G1_SET);
    dec.g1_clr = (addr == A_G1_CLR);
    dec.idx    = addr[3:0];
  end
endmodule

// File: rtl/actmon_enables.sv
module actmon_enables
  import actmon_pkg::*;
#(
  parameter int unsigned NUM_AUX = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_wr,
  input  decode_t            dec,
  input  logic [AUX_MAX-1:0] wbits,
  output logic [G0_NUM-1:0]  en0,
  output logic [AUX_MAX-1:0] en1
);
  localparam logic [AUX_MAX-1:0] AUX_IMPL = AUX_MAX'((33'd1 << NUM_AUX) - 33'd1);

  logic [G0_NUM-1:0]  en0_n;
  logic [AUX_MAX-1:0] en1_n;
  logic               upd;

  always_comb begin
    en0_n = en0;
    en1_n = en1;
    if (acc_wr && dec.g0_set) en0_n = en0 | wbits[G0_NUM-1:0];
    if (acc_wr && dec.g0_clr) en0_n = en0 & ~wbits[G0_NUM-1:0];
    if (acc_wr && dec.g1_set) en1_n = (en1 | wbits) & AUX_IMPL;
    if (acc_wr && dec.g1_clr) en1_n = en1 & ~wbits;
    upd = acc_wr && (dec.g0_set || dec.g0_clr || dec.g1_set || dec.g1_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en0 <= '0;
      en1 <= '0;
    end else if (upd) begin
      en0 <= en0_n;
      en1 <= en1_n;
    end
  end
endmodule

// File: rtl/actmon_counter.sv
module actmon_counter #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;
  logic         ce;

  always_comb begin
    ce  = ld | inc;
    q_n = ld ? ld_val : q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ce) q <= q_n;
  end
endmodule

// File: rtl/actmon_bank.sv
module actmon_bank
  import actmon_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned NUM_AUX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_wait,
  input  logic              ref_tick,
  input  logic              inst_retired,
  input  logic              llc_stall,
  input  logic [15:0]       aux_evt,
  input  logic              trap_lowpriv,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_lowpriv,
  input  logic [7:0]        req_addr,
  input  logic [CNT_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [CNT_W-1:0]  rsp_rdata
);
  decode_t                      dec;
  logic                         acc_ok, acc_wr;
  logic [G0_NUM-1:0]            en0;
  logic [AUX_MAX-1:0]           en1;
  logic [G0_NUM-1:0]            g0_evt;
  logic [G0_NUM-1:0]            g0_ld;
  logic [G0_NUM-1:0][CNT_W-1:0] g0_q;
  logic [AUX_MAX-1:0][CNT_W-1:0] g1_q;
  logic [CNT_W-1:0]             rd_val;
  logic                         rsp_valid_n, rsp_fault_n;
  logic [CNT_W-1:0]             rsp_rdata_n;

  actmon_decode u_dec (.addr(req_addr), .dec(dec));

  always_comb begin
    acc_ok = req_valid & ~(req_lowpriv & trap_lowpriv);
    acc_wr = acc_ok & req_write;
    g0_evt[EV_CYCLES]   = 1'b1;
    g0_evt[EV_REFTICK]  = ref_tick;
    g0_evt[EV_RETIRED]  = inst_retired;
    g0_evt[EV_LLCSTALL] = llc_stall;
  end

  actmon_enables #(.NUM_AUX(NUM_AUX)) u_en (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .dec(dec),
    .wbits(req_wdata[AUX_MAX-1:0]), .en0(en0), .en1(en1)
  );

  for (genvar i = 0; i < G0_NUM; i++) begin : g_fixed
    assign g0_ld[i] = acc_wr & dec.g0_cnt & (dec.idx[1:0] == 2'(i));
    actmon_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ld(g0_ld[i]), .ld_val(req_wdata),
      .inc(en0[i] & ~core_wait & g0_evt[i]), .q(g0_q[i])
    );
  end

  for (genvar i = 0; i < AUX_MAX; i++) begin : g_aux
    if (i < NUM_AUX) begin : g_on
      actmon_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .ld(acc_wr & dec.g1_cnt & (dec.idx == 4'(i))), .ld_val(req_wdata),
        .inc(en1[i] & ~core_wait & aux_evt[i]), .q(g1_q[i])
      );
    end else begin : g_off
      assign g1_q[i] = '0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (dec.g0_cnt)                rd_val = en0[dec.idx[1:0]] ? g0_q[dec.idx[1:0]] : '0;
    else if (dec.g1_cnt)           rd_val = en1[dec.idx] ? g1_q[dec.idx] : '0;
    else if (dec.g0_set || dec.g0_clr) rd_val = CNT_W'(en0);
    else if (dec.g1_set || dec.g1_clr) rd_val = CNT_W'(en1);
    rsp_valid_n = req_valid;
    rsp_fault_n = req_valid & ~acc_ok;
    rsp_rdata_n = (acc_ok & ~req_write) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_n;
      rsp_fault <= rsp_fault_n;
      rsp_rdata <= rsp_rdata_n;
    end
  end
endmodule

// File: rtl/actmon_bank_chk.sv
module actmon_bank_chk #(
  parameter int unsigned CNT_W = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     core_wait,
  input logic                     trap_lowpriv,
  input logic                     req_valid,
  input logic                     req_lowpriv,
  input logic [CNT_W-1:0]         req_wdata,
  input logic                     rsp_valid,
  input logic                     rsp_fault,
  input logic [CNT_W-1:0]         rsp_rdata,
  input logic [3:0]               en0,
  input logic [3:0]               g0_ld,
  input logic [3:0][CNT_W-1:0]    g0_q
);
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_trap_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_lowpriv && trap_lowpriv |=> rsp_fault && rsp_rdata == '0);
  p_no_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !(req_lowpriv && trap_lowpriv) |=> !rsp_fault);
  p_trap_no_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_lowpriv && trap_lowpriv && core_wait |=> $stable(g0_q) && $stable(en0));
  p_wait_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_wait && g0_ld == 4'b0 |=> $stable(g0_q));
  p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en0 == 4'b0 && g0_ld == 4'b0 |=> $stable(g0_q));
  p_cycle_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en0[0] && !core_wait && !g0_ld[0] |=> g0_q[0] == $past(g0_q[0]) + CNT_W'(1));
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    g0_ld[0] |=> g0_q[0] == $past(req_wdata));
endmodule

bind actmon_bank actmon_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_wait(core_wait), .trap_lowpriv(trap_lowpriv),
  .req_valid(req_valid), .req_lowpriv(req_lowpriv), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
  .en0(en0), .g0_ld(g0_ld), .g0_q(g0_q)
);

// File: tb/actmon_bank_bench.sv
module actmon_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;
  localparam int NAUX = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic core_wait = 1'b1, ref_tick = 1'b0, inst_retired = 1'b0, llc_stall = 1'b0;
  logic [15:0] aux_evt = '0;
  logic trap_lowpriv = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_lowpriv = 1'b0;
  logic [7:0] req_addr = '0;
  logic [W-1:0] req_wdata = '0;
  logic rsp_valid, rsp_fault;
  logic [W-1:0] rsp_rdata;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] rd;
  logic flt, vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  actmon_bank #(.CNT_W(W), .NUM_AUX(NAUX)) u_actmon_bank (.*);

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input bit lp, input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_lowpriv = lp; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_lowpriv = 1'b0;
    rd = rsp_rdata; flt = rsp_fault; vld = rsp_valid;
  endtask

  task automatic run(input int k);
    core_wait = 1'b0;
    repeat (k) @(negedge clk);
    core_wait = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rsp_valid after reset", W'(rsp_valid), 0);
    rst_n = 1'b1;
    acc(0, 0, 8'h20, 0); check("R1 g0 mask reset", rd, 0);
    acc(0, 0, 8'h22, 0); check("R1 g1 mask reset", rd, 0);
    acc(1, 0, 8'h20, 64'hF); acc(1, 0, 8'h22, 64'hF);
    for (int i = 0; i < 4; i++) begin acc(0, 0, 8'(i), 0); check("R1 fixed counter reset", rd, 0); end
    for (int i = 0; i < NAUX; i++) begin acc(0, 0, 8'(16 + i), 0); check("R1 aux counter reset", rd, 0); end

    // R2 R7 sweep of every fixed-group enable pattern, all events high
    ref_tick = 1; inst_retired = 1; llc_stall = 1;
    for (int m = 0; m < 16; m++) begin
      for (int i = 0; i < 4; i++) acc(1, 0, 8'(i), 0);
      acc(1, 0, 8'h21, 64'hF);
      acc(1, 0, 8'h20, W'(m));
      run(m + 1);
      for (int i = 0; i < 4; i++) begin
        acc(0, 0, 8'(i), 0);
        check("R2/R7 enable sweep", rd, m[i] ? W'(m + 1) : 0);
      end
    end

    // R2 distinct event patterns
    for (int i = 0; i < 4; i++) acc(1, 0, 8'(i), 0);
    for (int i = 0; i < 10; i++) begin
      ref_tick = (i % 2 == 0); inst_retired = (i % 3 == 0); llc_stall = (i < 4);
      if (i == 0) core_wait = 1'b0;
      @(negedge clk);
    end
    core_wait = 1'b1;
    acc(0, 0, 8'h00, 0); check("R2 cycles", rd, 10);
    acc(0, 0, 8'h01, 0); check("R2 ref ticks", rd, 5);
    acc(0, 0, 8'h02, 0); check("R2 retired", rd, 4);
    acc(0, 0, 8'h03, 0); check("R2 llc stalls", rd, 4);

    // R4 wait freezes counting
    ref_tick = 1; inst_retired = 1; llc_stall = 1; aux_evt = '1;
    repeat (5) @(negedge clk);
    acc(0, 0, 8'h00, 0); check("R4 frozen cycles", rd, 10);
    acc(0, 0, 8'h03, 0); check("R4 frozen stalls", rd, 4);
    acc(0, 0, 8'h10, 0); check("R4 frozen aux", rd, 0);

    // R7 disabled counter holds and reads zero
    acc(1, 0, 8'h00, 100);
    acc(1, 0, 8'h21, 64'h1);
    run(5);
    acc(0, 0, 8'h00, 0); check("R7 disabled reads zero", rd, 0);
    acc(1, 0, 8'h20, 64'h1);
    acc(0, 0, 8'h00, 0); check("R7 held value", rd, 100);

    // R3 auxiliary counters
    for (int i = 0; i < NAUX; i++) acc(1, 0, 8'(16 + i), 0);
    aux_evt = 16'h0005;
    run(3);
    aux_evt = '0;
    for (int i = 0; i < NAUX; i++) begin
      acc(0, 0, 8'(16 + i), 0); check("R3 aux count", rd, (i % 2 == 0) ? 3 : 0);
    end
    acc(1, 0, 8'h15, 77);
    acc(0, 0, 8'h15, 0); check("R3 absent index", rd, 0);

    // R5 R6 masks
    acc(1, 0, 8'h22, 64'hFFFF);
    acc(0, 0, 8'h22, 0); check("R6 absent mask bits", rd, 64'hF);
    acc(1, 0, 8'h23, 64'h2);
    acc(0, 0, 8'h23, 0); check("R5 clear one bit", rd, 64'hD);
    acc(1, 0, 8'h22, 64'h0);
    acc(0, 0, 8'h22, 0); check("R5 zero leaves mask", rd, 64'hD);
    acc(1, 0, 8'h21, 64'h0);
    acc(0, 0, 8'h21, 0); check("R5 zero clear keeps g0", rd, 64'hF);

    // R8 wrap
    acc(1, 0, 8'h00, '1);
    run(2);
    acc(0, 0, 8'h00, 0); check("R8 wrap", rd, 1);

    // R9 write beats increment
    @(negedge clk);
    core_wait = 1'b0;
    req_valid = 1; req_write = 1; req_lowpriv = 0; req_addr = 8'h00; req_wdata = 500;
    @(negedge clk);
    req_valid = 0; req_write = 0; core_wait = 1'b1;
    check("R11 write rsp data zero", rsp_rdata, 0);
    acc(0, 0, 8'h00, 0); check("R9 write priority", rd, 500);

    // R11 read shows value before edge
    @(negedge clk);
    core_wait = 1'b0;
    req_valid = 1; req_write = 0; req_addr = 8'h00;
    @(negedge clk);
    req_valid = 0; core_wait = 1'b1;
    check("R11 rsp_valid", W'(rsp_valid), 1);
    check("R11 pre-edge value", rsp_rdata, 500);
    @(negedge clk);
    check("R11 rsp_valid drops", W'(rsp_valid), 0);
    acc(0, 0, 8'h00, 0); check("R11 post-edge value", rd, 501);

    // R10 trap
    trap_lowpriv = 1;
    acc(1, 1, 8'h00, 7); check("R10 write fault", W'(flt), 1);
    acc(1, 1, 8'h21, 64'hF); check("R10 clear fault", W'(flt), 1);
    acc(0, 0, 8'h00, 0); check("R10 state unchanged", rd, 501);
    check("R10 privileged ok", W'(flt), 0);
    acc(0, 1, 8'h00, 0); check("R10 read fault", W'(flt), 1);
    check("R10 fault data zero", rd, 0);
    trap_lowpriv = 0;
    acc(0, 1, 8'h00, 0); check("R10 trap off", rd, 501);
    check("R10 trap off no fault", W'(flt), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule